// File: doc/BRIEF.md
# Over-Current Pulse-Skip and Shutdown Latch

This block sits beside the modulator of a synchronous buck converter and reacts to a single current-limit flag. The flag comes from a comparator that is not part of this block. Each rising edge of the switching clock starts one switching cycle, and the flag is sampled at that edge. A hit while the block is idle inhibits the high-side pulse of that cycle. The block then keeps the high side off for a fixed run of skip cycles.

A watch window of fixed length follows the skip run. A fresh hit at the start of any watch cycle is treated as a sustained overload. The block then sets a fault latch that holds the high side off and tells the converter supervisor to shut down. If the watch window passes without a hit, the block returns to idle and is ready for the next trip. The latch clears only when enable is dropped or when the synchronous power-on reset is applied.

Top module: `oc_guard`

## Requirements
- R1: With `en` high and the block idle, `lim_hit` high at a clock edge drives `hs_inhibit` high for the cycle that edge starts. `hs_inhibit` is visible after that edge. This edge is cycle 0 of a trip.
- R2: `hs_inhibit` stays high for the next `SKIP_CYC` cycles (default 8; cycles 1 to 8). The value of `lim_hit` in those cycles has no effect on the outputs, either then or later.
- R3: In watch cycles `SKIP_CYC+1` to `SKIP_CYC+WATCH_CYC` (default 9 to 16), `hs_inhibit` is low in every cycle whose starting edge sees `lim_hit` low.
- R4: `lim_hit` high at the starting edge of any watch cycle sets `oc_fault` and `hs_inhibit` high from that edge on.
- R5: After a watch window with no hit, the block is idle again. A hit at cycle 17 or later starts a new trip, exactly as R1 describes.
- R6: While `en` stays high, `oc_fault` stays set and `hs_inhibit` stays high, whatever `lim_hit` does.
- R7: `en` low at a clock edge clears `oc_fault` and `hs_inhibit` and returns the block to idle. While `en` is low, `lim_hit` starts no trip.
- R8: Synchronous active-high `rst` clears both outputs and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switching clock; each rising edge starts a cycle |
| rst | input | 1 | Synchronous active-high power-on reset |
| en | input | 1 | Converter enable; a low level clears the fault latch |
| lim_hit | input | 1 | Current-limit comparator output |
| hs_inhibit | output | 1 | Suppresses the high-side pulse for the current cycle |
| oc_fault | output | 1 | Latched over-current shutdown request |

## Verification
The main sweep starts a trip at cycle 0 and then places one second hit at every offset from 1 to 18. Offsets 1 to 8 show that hits during the skip run are ignored. Offsets 9 to 16 find each edge of the watch window, where the fault must latch. Offsets 17 and 18 show that the block has returned to idle and starts a new, clean trip. Further runs hold `lim_hit` high throughout, apply hits with enable low, clear a latched fault by dropping enable and by reset, and confirm that a fresh trip works after each clear.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OC_IDLE    = 2'd0,
    OC_SKIP    = 2'd1,
    OC_WATCH   = 2'd2,
    OC_LATCHED = 2'd3
  } oc_state_e;
endpackage

// File: rtl/oc_cycle_count.sv
module oc_cycle_count #(
  parameter int SKIP_CYC  = 8,
  parameter int WATCH_CYC = 8,
  localparam int TOTAL    = SKIP_CYC + WATCH_CYC,
  localparam int CNT_W    = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             last_skip,
  output logic             last_watch
);
  localparam logic [CNT_W-1:0] SKIP_END  = CNT_W'(SKIP_CYC);
  localparam logic [CNT_W-1:0] WATCH_END = CNT_W'(TOTAL);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= cnt + 1'b1;
  end

  assign last_skip  = (cnt == SKIP_END);
  assign last_watch = (cnt == WATCH_END);

  // Counter never runs past the end of the watch window (R5)
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= WATCH_END);
endmodule

// File: rtl/oc_trip_ctrl.sv
module oc_trip_ctrl
  import oc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      lim_hit,
  input  logic      last_skip,
  input  logic      last_watch,
  output logic      clr,
  output logic      adv,
  output oc_state_e state,
  output logic      hs_inhibit,
  output logic      oc_fault
);
  oc_state_e nxt;
  logic      inh_n, flt_n;

  always_comb begin
    nxt   = state;
    clr   = 1'b0;
    adv   = 1'b0;
    inh_n = 1'b0;
    flt_n = 1'b0;
    if (!en) begin
      nxt = OC_IDLE;
      clr = 1'b1;
    end else begin
      unique case (state)
        OC_IDLE: begin
          if (lim_hit) begin
            nxt   = OC_SKIP;
            adv   = 1'b1;
            inh_n = 1'b1;
          end else begin
            clr = 1'b1;
          end
        end
        OC_SKIP: begin
          adv   = 1'b1;
          inh_n = 1'b1;
          if (last_skip) nxt = OC_WATCH;
        end
        OC_WATCH: begin
          if (lim_hit) begin
            nxt   = OC_LATCHED;
            clr   = 1'b1;
            inh_n = 1'b1;
            flt_n = 1'b1;
          end else if (last_watch) begin
            nxt = OC_IDLE;
            clr = 1'b1;
          end else begin
            adv = 1'b1;
          end
        end
        OC_LATCHED: begin
          clr   = 1'b1;
          inh_n = 1'b1;
          flt_n = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= OC_IDLE;
      hs_inhibit <= 1'b0;
      oc_fault   <= 1'b0;
    end else begin
      state      <= nxt;
      hs_inhibit <= inh_n;
      oc_fault   <= flt_n;
    end
  end

  assert_trip_inhibit_R1: assert property (@(posedge clk) disable iff (rst)
    (en && state == OC_IDLE && lim_hit) |=> hs_inhibit);

  assert_skip_inhibit_R2: assert property (@(posedge clk) disable iff (rst)
    (state == OC_SKIP) |-> hs_inhibit);

  assert_watch_hit_latches_R4: assert property (@(posedge clk) disable iff (rst)
    (en && state == OC_WATCH && lim_hit) |=> oc_fault);

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (oc_fault && en) |=> oc_fault);

  assert_fault_inhibits_R6: assert property (@(posedge clk) disable iff (rst)
    oc_fault |-> hs_inhibit);

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!oc_fault && !hs_inhibit));
endmodule

// File: rtl/oc_guard.sv
module oc_guard #(
  parameter int SKIP_CYC  = 8,
  parameter int WATCH_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic lim_hit,
  output logic hs_inhibit,
  output logic oc_fault
);
  import oc_pkg::*;
  localparam int TOTAL = SKIP_CYC + WATCH_CYC;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic             clr, adv, last_skip, last_watch;
  logic [CNT_W-1:0] cnt;
  oc_state_e        state;

  oc_cycle_count #(.SKIP_CYC(SKIP_CYC), .WATCH_CYC(WATCH_CYC)) u_count (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv),
    .cnt(cnt), .last_skip(last_skip), .last_watch(last_watch)
  );

  oc_trip_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en(en), .lim_hit(lim_hit),
    .last_skip(last_skip), .last_watch(last_watch),
    .clr(clr), .adv(adv), .state(state),
    .hs_inhibit(hs_inhibit), .oc_fault(oc_fault)
  );

  // Idle means the cycle count rests at zero (R5, R7)
  assert_idle_count_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (state == OC_IDLE) |-> (cnt == '0));
endmodule

// File: tb/tb_oc_guard.sv
module tb_oc_guard;
  localparam int CLK_PERIOD = 10;
  localparam int SKIP = 8;
  localparam int WATCH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic lim_hit = 1'b0;
  logic hs_inhibit, oc_fault;
  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  oc_guard #(.SKIP_CYC(SKIP), .WATCH_CYC(WATCH)) dut (
    .clk(clk), .rst(rst), .en(en), .lim_hit(lim_hit),
    .hs_inhibit(hs_inhibit), .oc_fault(oc_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic e, input logic f);
    @(negedge clk);
    en = e;
    lim_hit = f;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic inh_exp, input logic flt_exp, input int tag);
    n_chk++;
    if (hs_inhibit !== inh_exp || oc_fault !== flt_exp) begin
      n_fail++;
      $display("FAIL %s step %0d: inhibit=%b fault=%b expected inhibit=%b fault=%b",
               req, tag, hs_inhibit, oc_fault, inh_exp, flt_exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check("R8", 1'b0, 1'b0, 0);
    @(negedge clk);
    rst = 1'b0;

    // R7: with enable low, hits start nothing
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1);
      check("R7", 1'b0, 1'b0, i);
    end

    // Sweep of second-hit offsets: R1 R2 R3 R4 R5 R6
    for (int k = 1; k <= 18; k++) begin
      for (int c = 0; c <= 40; c++) begin
        logic f, flt, inh;
        string req;
        f   = (c == 0) || (c == k);
        flt = (k >= SKIP+1) && (k <= SKIP+WATCH) && (c >= k);
        inh = (c <= SKIP) || flt ||
              ((k > SKIP+WATCH) && (c >= k) && (c <= k + SKIP));
        if (c == 0) req = "R1";
        else if (c <= SKIP) req = "R2";
        else if (flt) req = (c == k) ? "R4" : "R6";
        else if (c <= SKIP+WATCH) req = "R3";
        else req = "R5";
        step(1'b1, f);
        check(req, inh, flt, k * 100 + c);
      end
      step(1'b0, 1'b0);
      check("R7", 1'b0, 1'b0, k);
    end

    // Held-high flag latches at first watch cycle, then sticks (R4, R6)
    for (int c = 0; c <= 25; c++) begin
      step(1'b1, 1'b1);
      check(c == SKIP+1 ? "R4" : (c > SKIP+1 ? "R6" : "R2"),
            1'b1, c >= SKIP+1, 5000 + c);
    end
    // Clear by enable drop while flag still high (R7)
    step(1'b0, 1'b1);
    check("R7", 1'b0, 1'b0, 6000);
    // Fresh trip after clear (R1)
    step(1'b1, 1'b1);
    check("R1", 1'b1, 1'b0, 6001);
    for (int c = 1; c <= SKIP; c++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R4", 1'b1, 1'b1, 6002);
    // Reset clears the latch (R8)
    @(negedge clk);
    rst = 1'b1;
    lim_hit = 1'b0;
    @(posedge clk);
    #1;
    check("R8", 1'b0, 1'b0, 6003);
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 1'b1);
    check("R1", 1'b1, 1'b0, 6004);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule